// File: doc/BRIEF.md
# Timestamped Input Spike Scheduler

This block accepts a stream of received bytes that encode external input spike events and rebuilds each three-byte event into an input-source address and a time delta. The delta is the gap, in emulation time steps, since the previous event. The block adds each delta to a running total to get an absolute release step, and it stores the pair in a small first-in-first-out queue. That queue can take a new event and give up its oldest event in the same cycle.

A step counter advances on every time-step tick. When the counter equals the release step of the event at the head of the queue, the block pops that event and presents its address with a one-cycle valid pulse. Downstream logic uses that address to pick the row of feedforward weights to inject. Events that share a step leave one per cycle, in arrival order. The sender is told when the queue is full. A completed event that arrives while the queue is full is discarded and counted.

Top module: `spike_sched`

## Requirements
- R1: After reset, `ev_valid` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `ovf_count` is 0. The step counter and the time total both start at 0.
- R2: Bytes are taken in groups of three: the address high byte, then the address low byte, then the 8-bit unsigned delta. The released address is {first byte, second byte}.
- R3: A completed event that arrives while `fifo_full` is 1 is discarded, and `ovf_count` goes up by one, saturating at its maximum. `ovf_count` changes at no other time.
- R4: An event's release step is the sum of all deltas received since reset. The event is released only in a cycle where the step counter equals that sum, never earlier.
- R5: Events with a delta of 0 share the previous event's step. All events due in one step are released on consecutive cycles, one per cycle, in arrival order.
- R6: A delta of 0xFF is a plain gap of 255 steps.
- R7: The queue accepts a new event in the same cycle it releases one. A train longer than the queue depth streams in while the queue drains, and nothing is lost.
- R8: `fifo_full` is 1 exactly when DEPTH events are held, and `fifo_empty` is 1 exactly when none are held.
- R9: The delta of a discarded event still adds to the running total, so later events keep their intended steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` is valid this cycle |
| step_tick | input | 1 | Advance the step counter by one |
| ev_addr | output | ADDR_W | Address of the released event |
| ev_valid | output | 1 | One-cycle pulse for each released event |
| fifo_full | output | 1 | Queue holds DEPTH events |
| fifo_empty | output | 1 | Queue holds no events |
| ovf_count | output | OVF_W | Number of discarded events, saturating |

## Verification
The tests cover four kinds of input:
- A single event with a small delta. Ticking one step at a time separates an early release from a correct one.
- A burst of zero-delta events. This shows whether same-step events come out back to back and in order.
- A 0xFF delta. This shows whether the value is decoded as a plain gap.
- A train longer than the queue. It is sent first with no releases pending, to test the full flag, overflow counting and the running total past discarded events. It is sent again while the queue drains, to test simultaneous push and pop.

// File: rtl/spike_sched.sv
module spike_sched #(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 16,
  parameter int DEPTH  = 16,
  parameter int OVF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  input  logic              step_tick,
  output logic [ADDR_W-1:0] ev_addr,
  output logic              ev_valid,
  output logic              fifo_full,
  output logic              fifo_empty,
  output logic [OVF_W-1:0]  ovf_count
);
  localparam int AW = $clog2(DEPTH);

  logic [1:0]        bsel;
  logic [7:0]        hi_q, lo_q;
  logic [STEP_W-1:0] t_acc, step_cnt;
  logic [AW:0]       wr_ptr, rd_ptr;
  logic [ADDR_W-1:0] mem_a [DEPTH];
  logic [STEP_W-1:0] mem_t [DEPTH];

  wire              word_done = rx_valid && (bsel == 2'd2);
  wire [STEP_W-1:0] t_new     = t_acc + STEP_W'(rx_byte);
  wire [ADDR_W-1:0] a_new     = ADDR_W'({hi_q, lo_q});

  assign fifo_empty = (wr_ptr == rd_ptr);
  assign fifo_full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);

  wire push = word_done && !fifo_full;
  wire pop  = !fifo_empty && (mem_t[rd_ptr[AW-1:0]] == step_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsel <= '0;
      hi_q <= '0;
      lo_q <= '0;
      t_acc <= '0;
    end else if (rx_valid) begin
      case (bsel)
        2'd0: hi_q <= rx_byte;
        2'd1: lo_q <= rx_byte;
        default: t_acc <= t_new;
      endcase
      bsel <= (bsel == 2'd2) ? 2'd0 : bsel + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         step_cnt <= '0;
    else if (step_tick) step_cnt <= step_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_a[wr_ptr[AW-1:0]] <= a_new;
      mem_t[wr_ptr[AW-1:0]] <= t_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      ev_valid  <= 1'b0;
      ev_addr   <= '0;
      ovf_count <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      ev_valid <= pop;
      if (pop) ev_addr <= mem_a[rd_ptr[AW-1:0]];
      if (word_done && fifo_full && ovf_count != '1)
        ovf_count <= ovf_count + 1'b1;
    end
  end
endmodule

// File: rtl/spike_sched_chk.sv
module spike_sched_chk #(
  parameter int OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             ev_valid,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic [OVF_W-1:0] ovf_count
);
  p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> ($past(fifo_full) && $past(rx_valid)));

  p_ovf_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_count != $past(ovf_count)) |-> (ovf_count == $past(ovf_count) + 1'b1));

  p_release_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(!fifo_empty));

  p_empty_no_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |=> !ev_valid);
endmodule

bind spike_sched spike_sched_chk #(.OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .ev_valid(ev_valid),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf_count(ovf_count)
);

// File: tb/test_spike_sched.sv
module test_spike_sched;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid = 1'b0;
  logic        step_tick = 1'b0;
  logic [15:0] ev_addr;
  logic        ev_valid, fifo_full, fifo_empty;
  logic [7:0]  ovf_count;

  spike_sched #(.DEPTH(DEPTH)) i_spike_sched (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .step_tick(step_tick), .ev_addr(ev_addr), .ev_valid(ev_valid),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .ovf_count(ovf_count)
  );

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  int tb_step = 0, cyc = 0;
  int rel_n = 0;
  logic [15:0] rel_addr [64];
  int          rel_step [64];
  int          rel_cyc  [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n && ev_valid && rel_n < 64) begin
    rel_addr[rel_n] = ev_addr;
    rel_step[rel_n] = tb_step;
    rel_cyc[rel_n]  = cyc;
    rel_n = rel_n + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic send_ev(input logic [15:0] a, input logic [7:0] d);
    send_byte(a[15:8]); send_byte(a[7:0]); send_byte(d);
    repeat (2) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); step_tick = 1'b1; tb_step = tb_step + 1;
    @(negedge clk); step_tick = 1'b0;
    repeat (28) @(negedge clk);
  endtask

  task automatic test_reset();
    chk("R1 ev_valid", ev_valid, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 ovf", ovf_count, 0);
  endtask

  task automatic test_basic();
    rel_n = 0;
    send_ev(16'h1234, 8'd3);
    tick(); tick();
    chk("R4 not early", rel_n, 0);
    tick();
    chk("R4 released", rel_n, 1);
    chk("R2 address", rel_addr[0], 16'h1234);
    chk("R4 step", rel_step[0], 3);
  endtask

  task automatic test_zero_burst();
    rel_n = 0;
    send_ev(16'hA001, 8'd2);
    send_ev(16'hB002, 8'd0);
    send_ev(16'hC003, 8'd0);
    tick();
    chk("R5 not early", rel_n, 0);
    tick();
    chk("R5 count", rel_n, 3);
    chk("R5 order0", rel_addr[0], 16'hA001);
    chk("R5 order1", rel_addr[1], 16'hB002);
    chk("R5 order2", rel_addr[2], 16'hC003);
    chk("R5 step", rel_step[2], 5);
    chk("R5 back to back", rel_cyc[2] - rel_cyc[0], 2);
  endtask

  task automatic test_ff_gap();
    rel_n = 0;
    send_ev(16'h00FF, 8'hFF);
    for (int i = 0; i < 254; i++) tick();
    chk("R6 not early", rel_n, 0);
    tick();
    chk("R6 released", rel_n, 1);
    chk("R6 step", rel_step[0], 260);
    chk("R6 address", rel_addr[0], 16'h00FF);
  endtask

  task automatic test_overflow();
    rel_n = 0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      send_ev(16'h4000 + 16'(i), 8'd1);
      if (i == DEPTH - 2) chk("R8 not full yet", fifo_full, 0);
    end
    chk("R8 full", fifo_full, 1);
    chk("R8 not empty", fifo_empty, 0);
    chk("R3 ovf count", ovf_count, 2);
    for (int i = 0; i < DEPTH; i++) tick();
    chk("R3 kept count", rel_n, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 kept address", rel_addr[i], 16'h4000 + i);
      chk("R4 kept step", rel_step[i], 261 + i);
    end
    chk("R8 empty", fifo_empty, 1);
    rel_n = 0;
    send_ev(16'h5555, 8'd1);
    repeat (3) tick();
    chk("R9 released", rel_n, 1);
    chk("R9 step", rel_step[0], 279);
  endtask

  task automatic test_stream();
    rel_n = 0;
    send_ev(16'h6000, 8'd1);
    for (int i = 1; i < 10; i++) send_ev(16'h6000 + 16'(i), 8'd0);
    fork
      tick();
      for (int i = 10; i < 20; i++) send_ev(16'h6000 + 16'(i), 8'd0);
    join
    repeat (5) @(negedge clk);
    chk("R7 count", rel_n, 20);
    for (int i = 0; i < 20; i++) begin
      chk("R7 order", rel_addr[i], 16'h6000 + i);
      chk("R7 step", rel_step[i], 280);
    end
    chk("R7 no ovf", ovf_count, 2);
    chk("R7 drained", fifo_empty, 1);
  endtask

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_zero_burst();
    test_ff_gap();
    test_overflow();
    test_stream();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule